// File: doc/BRIEF.md
# OUT endpoint transfer size tracker

This block keeps the transfer-size control word of one device-side USB OUT endpoint. Software arms a transfer by writing a byte budget and a packet budget into a 32-bit word and reads the word back at any time. The receive path pulses a strobe each time a full packet lands in the receive FIFO, with its data PID and a flag marking SETUP tokens. The drain path pulses a strobe each time a packet leaves the FIFO for memory, with its byte length.

The packet budget counts down on receive events and the byte budget counts down on drain events. When the byte budget reaches zero on an enabled endpoint, a one-cycle completion interrupt fires. Writing the byte budget as one maximum packet gives one interrupt per packet. A 2-bit read-only status field has two meanings. On an isochronous endpoint it holds the PID of the latest packet. On a control endpoint it holds how many back-to-back SETUP packets may still be accepted, and a SETUP packet that arrives with no allowance left raises an overflow pulse.

Top module: `ep_out_xfer_tracker`

## Requirements
- R1: The read word holds the byte budget in bits 18:0, the packet budget in bits 28:19 and the status field in bits 30:29. Bit 31 always reads 0, whatever is written to it.
- R2: Reset clears every field to zero. A write loads the byte and packet budgets from the write data. Write data in bits 30:29 does not change the status field.
- R3: Each receive strobe lowers the packet budget by one. The packet budget holds at zero and does not wrap.
- R4: Each drain strobe lowers the byte budget by the drain length. If the length is at least the remaining budget, the budget becomes zero.
- R5: The completion output pulses for exactly one cycle, in the cycle after a drain takes the byte budget from non-zero to zero. It pulses only if the endpoint enable was high for that drain.
- R6: On an isochronous endpoint (type code 01), each receive strobe loads the status field with the packet PID. The encoding is 00 for DATA0, 01 for DATA2, 10 for DATA1 and 11 for MDATA.
- R7: On a control endpoint (type code 00), a software write sets the status field to 11, which allows three SETUP packets. Each received SETUP packet lowers the field by one, through 10 (two) and 01 (one) down to 00 (none).
- R8: On a control endpoint, a SETUP packet received while the status field is 00 pulses the overflow output for one cycle in the following cycle. The status field stays at 00.
- R9: A software write wins over a drain or receive decrement of the same field in the same cycle.
- R10: A change of the endpoint-type input clears the status field to zero. This clear wins over a same-cycle write reload.
- R11: On bulk (10) or interrupt (11) endpoints, the status field stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Software write strobe |
| reg_wdata_i | input | 32 | Software write data |
| reg_rdata_o | output | 32 | Current control word |
| ep_type_i | input | 2 | Endpoint type: 00 control, 01 isochronous, 10 bulk, 11 interrupt |
| ep_enable_i | input | 1 | Endpoint enabled; gates the completion pulse |
| rx_pkt_i | input | 1 | Packet written into receive FIFO |
| rx_pid_i | input | 2 | PID code of that packet |
| rx_setup_i | input | 1 | That packet is a SETUP packet |
| drain_pkt_i | input | 1 | Packet moved from FIFO to memory |
| drain_len_i | input | 11 | Byte length of the drained packet |
| xfer_done_o | output | 1 | Transfer-complete pulse |
| setup_ovf_o | output | 1 | SETUP allowance overflow pulse |

## Verification
The bench builds the block with its default widths: a 19-bit byte budget, a 10-bit packet budget and an 11-bit drain length. With these widths a full all-ones write fills every writable bit of the word, so the reserved bit and the field edges can be seen in a single read. A drain of the largest length, 2047 bytes, can hit a byte budget that is smaller, equal or larger, so the saturating and plain subtract paths are both reached. The packet budget is kept small, so its hold at zero shows within a few receive strobes.

// File: rtl/ep_out_pkg.sv
package ep_out_pkg;
  localparam int REG_W     = 32;
  localparam int STS_W     = 2;
  localparam int SETUP_MAX = 3;

  typedef enum logic [1:0] {
    EP_CTRL = 2'd0,
    EP_ISO  = 2'd1,
    EP_BULK = 2'd2,
    EP_INTR = 2'd3
  } ep_kind_e;
endpackage

// File: rtl/ep_byte_cnt.sv
module ep_byte_cnt #(
  parameter int W     = 19,
  parameter int LEN_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [W-1:0]     ld_val_i,
  input  logic             dec_i,
  input  logic [LEN_W-1:0] dec_len_i,
  input  logic             en_i,
  output logic [W-1:0]     cnt_o,
  output logic             zero_hit_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] len_x;
  logic         drains_out;

  assign len_x      = {{(W-LEN_W){1'b0}}, dec_len_i};
  assign drains_out = (len_x >= cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      zero_hit_o <= 1'b0;
    end else begin
      zero_hit_o <= 1'b0;
      if (ld_i) begin
        cnt_q <= ld_val_i;
      end else if (dec_i) begin
        // saturate instead of wrapping
        cnt_q      <= drains_out ? '0 : cnt_q - len_x;
        zero_hit_o <= en_i && (cnt_q != '0) && drains_out;
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ep_pkt_cnt.sv
module ep_pkt_cnt #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (ld_i)                  cnt_q <= ld_val_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ep_status_fld.sv
module ep_status_fld
  import ep_out_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ep_kind_e         kind_i,
  input  logic             kind_chg_i,
  input  logic             sw_we_i,
  input  logic             rx_pkt_i,
  input  logic             rx_setup_i,
  input  logic [STS_W-1:0] rx_pid_i,
  output logic [STS_W-1:0] sts_o,
  output logic             ovf_o
);
  logic [STS_W-1:0] sts_q;
  logic             setup_in;

  assign setup_in = rx_pkt_i && rx_setup_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      ovf_o <= 1'b0;
      if (kind_chg_i) begin
        sts_q <= '0;
      end else begin
        unique case (kind_i)
          EP_CTRL: begin
            if (sw_we_i)                     sts_q <= STS_W'(SETUP_MAX);
            else if (setup_in && sts_q != '0) sts_q <= sts_q - 1'b1;
            else if (setup_in)               ovf_o <= 1'b1;
          end
          EP_ISO: if (rx_pkt_i) sts_q <= rx_pid_i;
          default: sts_q <= '0;
        endcase
      end
    end
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/ep_out_xfer_tracker.sv
module ep_out_xfer_tracker
  import ep_out_pkg::*;
#(
  parameter int XFER_W = 19,
  parameter int PKT_W  = 10,
  parameter int LEN_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [1:0]        ep_type_i,
  input  logic              ep_enable_i,
  input  logic              rx_pkt_i,
  input  logic [STS_W-1:0]  rx_pid_i,
  input  logic              rx_setup_i,
  input  logic              drain_pkt_i,
  input  logic [LEN_W-1:0]  drain_len_i,
  output logic              xfer_done_o,
  output logic              setup_ovf_o
);
  localparam int PKT_LSB = XFER_W;
  localparam int STS_LSB = XFER_W + PKT_W;

  ep_kind_e         kind;
  ep_kind_e         kind_q;
  logic             kind_chg;
  logic [XFER_W-1:0] size_cnt;
  logic [PKT_W-1:0]  pkt_cnt;
  logic [STS_W-1:0]  sts;

  assign kind     = ep_kind_e'(ep_type_i);
  assign kind_chg = (kind != kind_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kind_q <= EP_CTRL;
    else         kind_q <= kind;
  end

  ep_byte_cnt #(.W(XFER_W), .LEN_W(LEN_W)) i_byte_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_i       (reg_we_i),
    .ld_val_i   (reg_wdata_i[XFER_W-1:0]),
    .dec_i      (drain_pkt_i),
    .dec_len_i  (drain_len_i),
    .en_i       (ep_enable_i),
    .cnt_o      (size_cnt),
    .zero_hit_o (xfer_done_o)
  );

  ep_pkt_cnt #(.W(PKT_W)) i_pkt_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (reg_we_i),
    .ld_val_i (reg_wdata_i[PKT_LSB +: PKT_W]),
    .dec_i    (rx_pkt_i),
    .cnt_o    (pkt_cnt)
  );

  ep_status_fld i_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kind_i     (kind),
    .kind_chg_i (kind_chg),
    .sw_we_i    (reg_we_i),
    .rx_pkt_i   (rx_pkt_i),
    .rx_setup_i (rx_setup_i),
    .rx_pid_i   (rx_pid_i),
    .sts_o      (sts),
    .ovf_o      (setup_ovf_o)
  );

  always_comb begin
    reg_rdata_o                       = '0;
    reg_rdata_o[XFER_W-1:0]           = size_cnt;
    reg_rdata_o[PKT_LSB +: PKT_W]     = pkt_cnt;
    reg_rdata_o[STS_LSB +: STS_W]     = sts;
  end
endmodule

// File: rtl/ep_out_xfer_tracker_chk.sv
module ep_out_xfer_tracker_chk
  import ep_out_pkg::*;
#(
  parameter int XFER_W = 19,
  parameter int PKT_W  = 10,
  parameter int LEN_W  = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic [REG_W-1:0]  reg_rdata_o,
  input logic [1:0]        ep_type_i,
  input logic              ep_enable_i,
  input logic              rx_pkt_i,
  input logic [STS_W-1:0]  rx_pid_i,
  input logic              rx_setup_i,
  input logic              drain_pkt_i,
  input logic [LEN_W-1:0]  drain_len_i,
  input logic              xfer_done_o,
  input logic              setup_ovf_o
);
  localparam int PKT_LSB = XFER_W;
  localparam int STS_LSB = XFER_W + PKT_W;
  localparam int LOW_W   = XFER_W + PKT_W;

  logic [PKT_W-1:0] pkt;
  logic [XFER_W-1:0] sz;
  logic [STS_W-1:0]  sts;
  logic              seen_q;
  logic [1:0]        ty_q;
  logic              ty_same;

  assign pkt = reg_rdata_o[PKT_LSB +: PKT_W];
  assign sz  = reg_rdata_o[XFER_W-1:0];
  assign sts = reg_rdata_o[STS_LSB +: STS_W];
  assign ty_same = seen_q && (ep_type_i == ty_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      ty_q   <= '0;
    end else begin
      seen_q <= 1'b1;
      ty_q   <= ep_type_i;
    end
  end

  p_rsvd_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[REG_W-1] == 1'b0);

  p_sw_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> reg_rdata_o[LOW_W-1:0] == $past(reg_wdata_i[LOW_W-1:0]));

  p_pkt_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_we_i && rx_pkt_i && pkt != '0) |=> pkt == $past(pkt) - 1'b1);

  p_pkt_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_we_i && pkt == '0) |=> pkt == '0);

  p_done_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |-> sz == '0);

  p_done_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |-> $past(ep_enable_i && drain_pkt_i && !reg_we_i));

  p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |=> !xfer_done_o);

  p_iso_pid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ty_same && ep_type_i == EP_ISO && rx_pkt_i) |=> sts == $past(rx_pid_i));

  p_setup_dec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ty_same && ep_type_i == EP_CTRL && !reg_we_i && rx_pkt_i && rx_setup_i && sts != '0)
    |=> sts == $past(sts) - 1'b1);

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_ovf_o |-> (sts == '0) && $past(rx_pkt_i && rx_setup_i && ep_type_i == EP_CTRL));

  p_type_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && ep_type_i != ty_q) |=> sts == '0);

  p_bulk_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ty_same && ep_type_i[1]) |=> sts == '0);
endmodule

bind ep_out_xfer_tracker ep_out_xfer_tracker_chk #(
  .XFER_W(XFER_W), .PKT_W(PKT_W), .LEN_W(LEN_W)
) i_chk (.*);

// File: tb/test_ep_out_xfer_tracker.sv
module test_ep_out_xfer_tracker;
  localparam int N = 24;

  typedef struct packed {
    logic        we;
    logic [31:0] wdata;
    logic [1:0]  typ;
    logic        en;
    logic        rx;
    logic [1:0]  pid;
    logic        setup;
    logic        drain;
    logic [10:0] len;
    logic [31:0] exp;
    logic        done;
    logic        ovf;
    logic [3:0]  req;
  } vec_t;

  function automatic logic [31:0] mk(input logic [1:0] s, input int p, input int z);
    return {1'b0, s, 10'(p), 19'(z)};
  endfunction

  function automatic vec_t v(input logic we, input logic [31:0] wd, input logic [1:0] ty,
                             input logic en, input logic rx, input logic [1:0] pid,
                             input logic su, input logic dr, input int len,
                             input logic [31:0] ex, input logic dn, input logic ov,
                             input int rq);
    return '{we, wd, ty, en, rx, pid, su, dr, 11'(len), ex, dn, ov, 4'(rq)};
  endfunction

  localparam vec_t TBL [0:N-1] = '{
    v(1, 32'hE000_0000 | mk(0,3,100), 2, 1, 0, 0, 0, 0, 0,  mk(0,3,100), 0, 0, 1),  // R1 R2
    v(0, 0,            2, 1, 1, 0, 0, 0, 0,  mk(0,2,100), 0, 0, 3),  // R3
    v(0, 0,            2, 1, 0, 0, 0, 1, 60, mk(0,2,40),  0, 0, 4),  // R4
    v(0, 0,            2, 1, 0, 0, 0, 1, 60, mk(0,2,0),   1, 0, 5),  // R4 R5
    v(0, 0,            2, 1, 0, 0, 0, 1, 10, mk(0,2,0),   0, 0, 5),  // R5
    v(0, 0,            2, 1, 1, 0, 1, 0, 0,  mk(0,1,0),   0, 0, 11), // R11
    v(0, 0,            2, 1, 1, 0, 0, 0, 0,  mk(0,0,0),   0, 0, 3),  // R3
    v(0, 0,            2, 1, 1, 0, 0, 0, 0,  mk(0,0,0),   0, 0, 3),  // R3
    v(1, mk(0,5,64),   2, 1, 1, 0, 0, 1, 30, mk(0,5,64),  0, 0, 9),  // R9
    v(0, 0,            2, 0, 0, 0, 0, 1, 64, mk(0,5,0),   0, 0, 5),  // R5
    v(0, 0,            1, 1, 0, 0, 0, 0, 0,  mk(0,5,0),   0, 0, 10), // R10
    v(0, 0,            1, 1, 1, 2, 0, 0, 0,  mk(2,4,0),   0, 0, 6),  // R6
    v(0, 0,            1, 1, 1, 1, 0, 0, 0,  mk(1,3,0),   0, 0, 6),  // R6
    v(1, 32'hE000_0000 | mk(0,7,200), 1, 1, 0, 0, 0, 0, 0, mk(1,7,200), 0, 0, 2), // R2
    v(0, 0,            0, 1, 0, 0, 0, 0, 0,  mk(0,7,200), 0, 0, 10), // R10
    v(1, mk(0,7,200),  0, 1, 0, 0, 0, 0, 0,  mk(3,7,200), 0, 0, 7),  // R7
    v(0, 0,            0, 1, 1, 0, 1, 0, 0,  mk(2,6,200), 0, 0, 7),  // R7
    v(0, 0,            0, 1, 1, 0, 1, 0, 0,  mk(1,5,200), 0, 0, 7),  // R7
    v(0, 0,            0, 1, 1, 0, 1, 0, 0,  mk(0,4,200), 0, 0, 7),  // R7
    v(0, 0,            0, 1, 1, 0, 1, 0, 0,  mk(0,3,200), 0, 1, 8),  // R8
    v(0, 0,            0, 1, 1, 3, 0, 0, 0,  mk(0,2,200), 0, 0, 8),  // R8
    v(0, 0,            0, 1, 0, 0, 0, 1, 200, mk(0,2,0),  1, 0, 5),  // R5
    v(0, 0,            1, 1, 0, 0, 0, 0, 0,  mk(0,2,0),   0, 0, 10), // R10
    v(1, mk(0,1,5),    0, 1, 0, 0, 0, 0, 0,  mk(0,1,5),   0, 0, 10)  // R10
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [1:0]  ep_type_i = 2'd2;
  logic        ep_enable_i = 1'b1;
  logic        rx_pkt_i = 1'b0;
  logic [1:0]  rx_pid_i = '0;
  logic        rx_setup_i = 1'b0;
  logic        drain_pkt_i = 1'b0;
  logic [10:0] drain_len_i = '0;
  logic        xfer_done_o;
  logic        setup_ovf_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  ep_out_xfer_tracker i_ep_out_xfer_tracker (.*);

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic idle();
    reg_we_i = 0; rx_pkt_i = 0; rx_setup_i = 0; drain_pkt_i = 0;
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    // R2 reset state
    check("R2 reset word", reg_rdata_o, 32'h0);
    check("R2 reset done", {31'b0, xfer_done_o}, 32'h0);
    check("R2 reset ovf", {31'b0, setup_ovf_o}, 32'h0);

    for (int i = 0; i < N; i++) begin
      reg_we_i    = TBL[i].we;
      reg_wdata_i = TBL[i].wdata;
      ep_type_i   = TBL[i].typ;
      ep_enable_i = TBL[i].en;
      rx_pkt_i    = TBL[i].rx;
      rx_pid_i    = TBL[i].pid;
      rx_setup_i  = TBL[i].setup;
      drain_pkt_i = TBL[i].drain;
      drain_len_i = TBL[i].len;
      step();
      idle();
      check($sformatf("R%0d vec %0d word", TBL[i].req, i), reg_rdata_o, TBL[i].exp);
      check($sformatf("R%0d vec %0d done", TBL[i].req, i), {31'b0, xfer_done_o}, {31'b0, TBL[i].done});
      check($sformatf("R%0d vec %0d ovf", TBL[i].req, i), {31'b0, setup_ovf_o}, {31'b0, TBL[i].ovf});
    end

    // R1 all-ones write on bulk endpoint: bit 31 and status stay 0
    ep_type_i = 2'd2;
    step();
    reg_we_i = 1; reg_wdata_i = 32'hFFFF_FFFF;
    step();
    idle();
    check("R1 full write", reg_rdata_o, 32'h1FFF_FFFF);
    // R4 largest drain against a large budget
    drain_pkt_i = 1; drain_len_i = 11'd2047;
    step();
    idle();
    check("R4 max drain", reg_rdata_o, 32'h1FFF_F800);
    check("R5 no early done", {31'b0, xfer_done_o}, 32'h0);
    // R4 drain equal to budget
    reg_we_i = 1; reg_wdata_i = mk(0,1,2047);
    step();
    drain_pkt_i = 1; reg_we_i = 0; drain_len_i = 11'd2047;
    step();
    idle();
    check("R4 exact drain", reg_rdata_o, mk(0,1,0));
    check("R5 exact drain done", {31'b0, xfer_done_o}, 32'h1);
    step();
    check("R5 pulse width", {31'b0, xfer_done_o}, 32'h0);

    // R2 asynchronous reset mid-run
    reg_we_i = 1; reg_wdata_i = mk(0,9,9);
    step();
    idle();
    #3 rst_ni = 0;
    #2 check("R2 async reset", reg_rdata_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1;
    step();
    check("R2 after reset", reg_rdata_o, 32'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule